// File: doc/BRIEF.md
# System Clock Source Switch Controller

This block chooses which of four oscillators drives the system clock. Software asks for a new source by writing a 3-bit code into a protected select field. The block accepts the request only when all of these hold: the protected-write unlock is high, the code names a real source, the present and requested oscillators are both enabled, and the requested oscillator reports stable. If a request is refused, the present source stays in use and a sticky fail flag is set. Software clears that flag by writing 1 to it.

Each oscillator has an enable input and a raw ready input. The block passes each ready input through a short synchronizer. From that it produces a per-source stable flag, which reads 0 while the source is disabled. The committed choice drives a one-hot select vector for a downstream glitch-free clock mux. The same choice is also reported back in its 3-bit encoded form. The oscillators and the mux cells sit outside the block.

Top module: `sysclk_switch`

## Requirements
- R1: While reset is low, and on release, the outputs are: select readback 3'b111 (fast RC), one-hot output 4'b1000, fail flag 0, all stable flags 0.
- R2: The one-hot output always has exactly one bit set, and it follows the readback code. Code 3'b000 (fast crystal) maps to bit 0, 3'b001 (slow crystal) to bit 1, 3'b011 (slow RC) to bit 2, and 3'b111 (fast RC) to bit 3.
- R3: Take an unlocked select write whose listed target has its stable flag at 1, with both the current and target enables high. In the next cycle the readback equals the written code, the one-hot output moves to the target and the fail flag is 0.
- R4: An unlocked select write whose target is not stable, or where the current or target enable is low, leaves the readback and one-hot output unchanged and sets the fail flag in the next cycle.
- R5: An unlocked select write of an unlisted code (3'b010, 3'b100, 3'b101, 3'b110) is a failed switch. It sets the fail flag and keeps the current selection.
- R6: A select write with unlock low changes neither the selection nor the fail flag.
- R7: A fail-flag write with data 1 clears the flag in the next cycle, and one with data 0 has no effect. If a failing select write happens in the same cycle, the flag ends up set.
- R8: With its enable high, a source's stable flag rises SYNC_STAGES clock edges after its raw ready input rises (2 by default). The flag reads 0 in the same cycle its enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on control clock |
| rst_n | input | 1 | Active-low power-on reset |
| unlock | input | 1 | Protected-write unlock, must be high for select writes |
| sel_wr | input | 1 | Write strobe for the select field |
| sel_wdata | input | 3 | Requested source code |
| fail_wr | input | 1 | Write strobe for the fail flag |
| fail_wdata | input | 1 | Fail-flag write data, 1 clears |
| src_en | input | 4 | Per-source oscillator enables |
| src_ready | input | 4 | Raw per-source ready indications |
| src_onehot | output | 4 | One-hot source select for the clock mux |
| sel_rdata | output | 3 | Readback of the committed source code |
| src_stable | output | 4 | Per-source stable flags, 0 when disabled |
| switch_fail | output | 1 | Sticky switch-failure flag |

## Verification
The checker tests several things on every cycle: that the one-hot output is one-hot and agrees with the readback code, that an accepted request commits the written code, that a refused request sets the flag and keeps the selection, that a locked write changes nothing, and that a write-1 clears the flag. Some behaviour only the bench scenarios can show. These are the synchronizer latency of the stable flags and their immediate drop when an enable falls, the same-cycle priority between a clear and a failing request, and the reset values. The bench also covers switches that fail because the current source was disabled while the target looked ready.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;

    localparam int NUM_SRC = 4;
    localparam int SEL_W   = 3;

    // Source codes; the one-hot bit order below is fixed by these codes
    localparam logic [SEL_W-1:0] CODE_FAST_XTAL = 3'b000;
    localparam logic [SEL_W-1:0] CODE_SLOW_XTAL = 3'b001;
    localparam logic [SEL_W-1:0] CODE_SLOW_RC   = 3'b011;
    localparam logic [SEL_W-1:0] CODE_FAST_RC   = 3'b111;

    typedef struct packed {
        logic [SEL_W-1:0]   sel;
        logic [NUM_SRC-1:0] onehot;
        logic               fail;
    } sw_state_t;

    // Unlisted codes return all zeros
    function automatic logic [NUM_SRC-1:0] code_to_onehot(input logic [SEL_W-1:0] code);
        logic [NUM_SRC-1:0] oh;
        case (code)
            CODE_FAST_XTAL: oh = 4'b0001;
            CODE_SLOW_XTAL: oh = 4'b0010;
            CODE_SLOW_RC:   oh = 4'b0100;
            CODE_FAST_RC:   oh = 4'b1000;
            default:        oh = '0;
        endcase
        return oh;
    endfunction

endpackage

// File: rtl/sysclk_stable_sync.sv
module sysclk_stable_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic ready,
    output logic stable
);

    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = ready;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    // A disabled source never reads as stable
    assign stable = chain_q[STAGES-1] & en;

endmodule

// File: rtl/sysclk_switch_ctrl.sv
module sysclk_switch_ctrl
    import sysclk_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               unlock,
    input  logic               sel_wr,
    input  logic [SEL_W-1:0]   sel_wdata,
    input  logic               fail_wr,
    input  logic               fail_wdata,
    input  logic [NUM_SRC-1:0] src_en,
    input  logic [NUM_SRC-1:0] src_stable,
    output logic [SEL_W-1:0]   sel_q_o,
    output logic [NUM_SRC-1:0] onehot_q_o,
    output logic               fail_q_o
);

    sw_state_t st_d, st_q;

    logic [NUM_SRC-1:0] tgt_oh;
    logic               tgt_listed, cur_on, tgt_on, tgt_ready, req, accept;

    always_comb begin
        tgt_oh     = code_to_onehot(sel_wdata);
        tgt_listed = |tgt_oh;
        cur_on     = |(st_q.onehot & src_en);
        tgt_on     = |(tgt_oh & src_en);
        tgt_ready  = |(tgt_oh & src_stable);
        req        = sel_wr & unlock;
        accept     = tgt_listed & cur_on & tgt_on & tgt_ready;

        st_d = st_q;
        if (fail_wr && fail_wdata) begin
            st_d.fail = 1'b0;
        end
        // A switch outcome overrides a same-cycle clear
        if (req) begin
            if (accept) begin
                st_d.sel    = sel_wdata;
                st_d.onehot = tgt_oh;
                st_d.fail   = 1'b0;
            end else begin
                st_d.fail   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sel    <= CODE_FAST_RC;
            st_q.onehot <= code_to_onehot(CODE_FAST_RC);
            st_q.fail   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_q_o    = st_q.sel;
    assign onehot_q_o = st_q.onehot;
    assign fail_q_o   = st_q.fail;

endmodule

// File: rtl/sysclk_switch.sv
module sysclk_switch
    import sysclk_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               unlock,
    input  logic               sel_wr,
    input  logic [SEL_W-1:0]   sel_wdata,
    input  logic               fail_wr,
    input  logic               fail_wdata,
    input  logic [NUM_SRC-1:0] src_en,
    input  logic [NUM_SRC-1:0] src_ready,
    output logic [NUM_SRC-1:0] src_onehot,
    output logic [SEL_W-1:0]   sel_rdata,
    output logic [NUM_SRC-1:0] src_stable,
    output logic               switch_fail
);

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_sync
        sysclk_stable_sync #(
            .STAGES (SYNC_STAGES)
        ) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (src_en[g]),
            .ready  (src_ready[g]),
            .stable (src_stable[g])
        );
    end

    sysclk_switch_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .unlock     (unlock),
        .sel_wr     (sel_wr),
        .sel_wdata  (sel_wdata),
        .fail_wr    (fail_wr),
        .fail_wdata (fail_wdata),
        .src_en     (src_en),
        .src_stable (src_stable),
        .sel_q_o    (sel_rdata),
        .onehot_q_o (src_onehot),
        .fail_q_o   (switch_fail)
    );

endmodule

// File: rtl/sysclk_switch_chk.sv
module sysclk_switch_chk
    import sysclk_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               unlock,
    input logic               sel_wr,
    input logic [SEL_W-1:0]   sel_wdata,
    input logic               fail_wr,
    input logic               fail_wdata,
    input logic [NUM_SRC-1:0] src_en,
    input logic [NUM_SRC-1:0] src_onehot,
    input logic [SEL_W-1:0]   sel_rdata,
    input logic [NUM_SRC-1:0] src_stable,
    input logic               switch_fail
);

    logic [NUM_SRC-1:0] c_tgt;
    logic c_req, c_ok;

    assign c_tgt = code_to_onehot(sel_wdata);
    assign c_req = sel_wr & unlock;
    assign c_ok  = (|c_tgt) && (|(c_tgt & src_en)) && (|(src_onehot & src_en))
                   && (|(c_tgt & src_stable));

    a_r2_one_source: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(src_onehot) == 1);

    a_r2_code_agrees: assert property (@(posedge clk) disable iff (!rst_n)
        src_onehot == code_to_onehot(sel_rdata));

    a_r3_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (c_req && c_ok) |=> (sel_rdata == $past(sel_wdata)) && !switch_fail);

    // R4 and R5: refused request
    a_r4_keep_on_refuse: assert property (@(posedge clk) disable iff (!rst_n)
        (c_req && !c_ok) |=> switch_fail && $stable(sel_rdata) && $stable(src_onehot));

    a_r6_locked_select: assert property (@(posedge clk) disable iff (!rst_n)
        !c_req |=> $stable(sel_rdata) && $stable(src_onehot));

    a_r6_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!c_req && !(fail_wr && fail_wdata)) |=> $stable(switch_fail));

    a_r7_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_wr && fail_wdata && !c_req) |=> !switch_fail);

endmodule

bind sysclk_switch sysclk_switch_chk u_chk (.*);

// File: tb/sysclk_switch_tb.sv
module sysclk_switch_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       unlock = 1'b0;
    logic       sel_wr = 1'b0;
    logic [2:0] sel_wdata = 3'b0;
    logic       fail_wr = 1'b0;
    logic       fail_wdata = 1'b0;
    logic [3:0] src_en = 4'b1000;
    logic [3:0] src_ready = 4'b0000;
    logic [3:0] src_onehot;
    logic [2:0] sel_rdata;
    logic [3:0] src_stable;
    logic       switch_fail;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [2:0] m_sel = 3'b111;
    logic       m_fail = 1'b0;

    always #5 clk = ~clk;

    sysclk_switch u_dut (
        .clk(clk), .rst_n(rst_n), .unlock(unlock), .sel_wr(sel_wr),
        .sel_wdata(sel_wdata), .fail_wr(fail_wr), .fail_wdata(fail_wdata),
        .src_en(src_en), .src_ready(src_ready), .src_onehot(src_onehot),
        .sel_rdata(sel_rdata), .src_stable(src_stable), .switch_fail(switch_fail)
    );

    function automatic logic [3:0] exp_oh(input logic [2:0] c);
        if (c == 3'b000) return 4'b0001;
        if (c == 3'b001) return 4'b0010;
        if (c == 3'b011) return 4'b0100;
        if (c == 3'b111) return 4'b1000;
        return 4'b0000;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_state(input string tag);
        chk({tag, " sel"}, 32'(sel_rdata), 32'(m_sel));
        chk({tag, " onehot"}, 32'(src_onehot), 32'(exp_oh(m_sel)));
        chk({tag, " fail"}, 32'(switch_fail), 32'(m_fail));
    endtask

    task automatic set_src(input logic [3:0] en, input logic [3:0] rdy);
        @(negedge clk);
        src_en = en;
        src_ready = rdy;
        repeat (3) @(negedge clk);
    endtask

    // Stable flags are assumed settled (raw & enable)
    task automatic wr(input logic u, input logic [2:0] d, input logic fw, input logic fd);
        logic [3:0] t;
        logic [3:0] stb;
        logic ok;
        t   = exp_oh(d);
        stb = src_ready & src_en;
        ok  = (t != 0) && ((t & src_en) != 0) && ((exp_oh(m_sel) & src_en) != 0)
              && ((t & stb) != 0);
        @(negedge clk);
        unlock = u; sel_wr = 1'b1; sel_wdata = d; fail_wr = fw; fail_wdata = fd;
        @(negedge clk);
        unlock = 1'b0; sel_wr = 1'b0; fail_wr = 1'b0; fail_wdata = 1'b0;
        if (fw && fd) m_fail = 1'b0;
        if (u) begin
            if (ok) begin m_sel = d; m_fail = 1'b0; end
            else m_fail = 1'b1;
        end
    endtask

    task automatic fail_only(input logic fd);
        @(negedge clk);
        fail_wr = 1'b1; fail_wdata = fd;
        @(negedge clk);
        fail_wr = 1'b0; fail_wdata = 1'b0;
        if (fd) m_fail = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk_state("R1 in reset");
        chk("R1 stable in reset", 32'(src_stable), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_state("R1 after release");
        chk("R1 stable after release", 32'(src_stable), 32'h0);

        // R8 synchronizer latency and enable gating
        src_ready[3] = 1'b1;
        @(negedge clk);
        chk("R8 one edge", 32'(src_stable[3]), 32'h0);
        @(negedge clk);
        chk("R8 two edges", 32'(src_stable[3]), 32'h1);
        src_en[3] = 1'b0;
        #1 chk("R8 disabled reads 0", 32'(src_stable[3]), 32'h0);
        src_en[3] = 1'b1;
        #1 chk("R8 re-enabled", 32'(src_stable[3]), 32'h1);

        // R4 target disabled
        wr(1'b1, 3'b000, 1'b0, 1'b0);
        chk_state("R4 target off");
        // R7 write 0 no effect, write 1 clears
        fail_only(1'b0);
        chk_state("R7 write zero");
        fail_only(1'b1);
        chk_state("R7 write one");

        // R6 locked write ignored
        set_src(4'b1001, 4'b1001);
        wr(1'b0, 3'b000, 1'b0, 1'b0);
        chk_state("R6 locked");

        // R3 successful switch to fast crystal
        wr(1'b1, 3'b000, 1'b0, 1'b0);
        chk_state("R3 to fast xtal");
        chk("R3 sel", 32'(sel_rdata), 32'h0);

        // R5 unlisted codes
        wr(1'b1, 3'b010, 1'b0, 1'b0);
        chk_state("R5 code 010");
        fail_only(1'b1);
        wr(1'b1, 3'b110, 1'b0, 1'b0);
        chk_state("R5 code 110");

        // R6 locked write leaves fail set
        wr(1'b0, 3'b111, 1'b1, 1'b0);
        chk_state("R6 fail kept");

        // R7 priority: clear plus failing request ends set
        wr(1'b1, 3'b001, 1'b1, 1'b1);
        chk_state("R7 priority");
        chk("R7 flag set", 32'(switch_fail), 32'h1);

        // R4 current source disabled while target ready
        set_src(4'b1000, 4'b1001);
        wr(1'b1, 3'b111, 1'b0, 1'b0);
        chk_state("R4 current off");
        set_src(4'b1001, 4'b1001);

        // R3 success with concurrent clear
        wr(1'b1, 3'b111, 1'b1, 1'b1);
        chk_state("R3 back to fast rc");

        // Random phase, mainly R2/R3/R4/R5/R8
        for (int it = 0; it < 400; it++) begin
            logic [3:0] en;
            logic [3:0] rdy;
            logic [2:0] d;
            en  = 4'($urandom) | exp_oh(m_sel) & 4'(($urandom % 4 != 0) ? 4'hf : 4'h0);
            rdy = 4'($urandom) | 4'(($urandom % 2) ? en : 4'h0);
            set_src(en, rdy);
            chk("R8 random stable", 32'(src_stable), 32'(en & rdy));
            d = ($urandom % 5 == 0) ? 3'($urandom)
                : ((($urandom % 4) == 0) ? 3'b000 : (($urandom % 3) == 0) ? 3'b001
                   : (($urandom % 2) == 0) ? 3'b011 : 3'b111);
            wr(($urandom % 4) != 0, d, 1'($urandom), 1'($urandom));
            chk_state("R3 R4 R5 random");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule